// File: doc/BRIEF.md
# External Data Access Stretch Controller

This block shapes the bus timing of an external data access issued by a small CPU. The CPU side hands over one request at a time: a read or write flag, an address, write data and a choice between full 16-bit addressing and a short 8-bit form. The controller then drives an address bus, an active-high read or write strobe and an outgoing data bus for a number of clocks set by a 3-bit stretch setting. At the end it pulses a completion flag and, for reads, presents the byte it sampled from the incoming data bus.

The stretch setting sits in a small register inside the block. It may be rewritten at any time, and each access takes its copy of the setting when it starts. Reads and writes stretch differently. A read holds its strobe for the whole address phase. A write keeps a longer address phase and places a narrower strobe inside it, so the address settles before the strobe and, from setting 1 upward, also holds after it.

Top module: `xmem_stretch_ctrl`

## Requirements
- R1: After reset the stretch register reads 1, `busy` and `done` are low, and both strobes are low.
- R2: A write to the stretch register (`cfg_we`) is visible on `cfg_stretch` on the next clock. It does not change an access already in progress and governs the next access that starts.
- R3: For stretch value s (0..7), a read keeps `busy` and a valid address for s+1 clocks, with `bus_rd` high during every one of those clocks.
- R4: For stretch value s, a write keeps `busy` and a valid address for s+2 clocks.
- R5: The write strobe stays high for 1 clock when s is 0 or 1, and for s clocks when s is 2 to 7.
- R6: The write strobe rises on the second clock of the address phase (index 1). For s of 1 or more, the address phase has exactly one clock left after the strobe falls.
- R7: When `req_short` is 1 the address bus carries 8'h00 in bits 15:8 and the request's bits 7:0. When it is 0 all 16 bits come from `req_addr`. The address is constant for the whole access.
- R8: `done` is high for exactly one clock, in the clock right after the last address clock. For a read, `rdata` then holds the value `bus_din` had on the last clock of the read strobe.
- R9: A request is taken only when `busy` is low. `req_valid` asserted while busy is ignored and starts no access.
- R10: While idle both strobes are low, and the two strobes are never high together. During the write strobe `bus_dout` carries the request's write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write enable for the stretch register |
| cfg_wdata | input | 3 | New stretch value |
| cfg_stretch | output | 3 | Current stretch register contents |
| req_valid | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_short | input | 1 | 1 = 8-bit address form, upper byte forced to zero |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Data to write |
| busy | output | 1 | Address phase in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| bus_addr | output | 16 | External address bus, zero while idle |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_dout | output | 8 | Outgoing data bus |
| bus_din | input | 8 | Incoming data bus |

## Verification
The bench runs every stretch value in both directions and both address forms. It measures the address phase, the width of each strobe and the clock on which the write strobe rises. A design that used the read length for writes, or that gave stretch 0 and 1 a write strobe other than one clock wide, would miss by one clock. The bench drives a different byte on `bus_din` on every clock, so a capture taken one clock early or late shows up as a wrong `rdata`. Further cases rewrite the stretch register in mid-access and hold `req_valid` while busy, which catches a design that applies the new setting at once or restarts on the held request.

// File: rtl/xms_pkg.sv
package xms_pkg;

  // address-phase length of a read, in clocks
  function automatic int unsigned rd_len(int unsigned s);
    return s + 1;
  endfunction

  // address-phase length of a write, in clocks
  function automatic int unsigned wr_len(int unsigned s);
    return s + 2;
  endfunction

  // write strobe width: never below one clock
  function automatic int unsigned wr_width(int unsigned s);
    return (s < 2) ? 1 : s;
  endfunction

  // phase index where the write strobe rises
  function automatic int unsigned wr_first(int unsigned s);
    return (s == 0) ? 1 : 1;
  endfunction

endpackage

// File: rtl/xms_stretch_reg.sv
module xms_stretch_reg #(
  parameter int unsigned SW        = 3,
  parameter int unsigned RESET_VAL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wdata,
  output logic [SW-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  value <= SW'(RESET_VAL);
    else if (we) value <= wdata;
  end
endmodule

// File: rtl/xms_phase_ctr.sv
module xms_phase_ctr #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          active,
  output logic [CW-1:0] idx,
  output logic          last
);
  assign last = active && (idx == len - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      idx    <= idx + CW'(1);
    end
  end
endmodule

// File: rtl/xms_strobe_gen.sv
module xms_strobe_gen #(
  parameter int unsigned SW = 3,
  parameter int unsigned CW = 4
) (
  input  logic          active,
  input  logic          is_write,
  input  logic [SW-1:0] stretch,
  input  logic [CW-1:0] idx,
  output logic [CW-1:0] len,
  output logic          rd,
  output logic          wr
);
  logic [CW-1:0] wr_lo, wr_hi;

  always_comb begin
    len   = is_write ? CW'(xms_pkg::wr_len(int'(stretch)))
                     : CW'(xms_pkg::rd_len(int'(stretch)));
    wr_lo = CW'(xms_pkg::wr_first(int'(stretch)));
    wr_hi = wr_lo + CW'(xms_pkg::wr_width(int'(stretch)));
    rd    = active && !is_write;
    wr    = active && is_write && (idx >= wr_lo) && (idx < wr_hi);
  end
endmodule

// File: rtl/xmem_stretch_ctrl.sv
module xmem_stretch_ctrl #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SW        = 3,
  parameter int unsigned RESET_STR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SW-1:0]     cfg_wdata,
  output logic [SW-1:0]     cfg_stretch,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_short,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din
);
  localparam int unsigned CW      = SW + 1;
  localparam int unsigned SHORT_W = 8;

  logic              accept;
  logic              cur_write;
  logic              cur_short;
  logic [SW-1:0]     cur_stretch;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic [CW-1:0]     len;
  logic [CW-1:0]     idx;
  logic              last;
  logic              rd_s, wr_s;

  assign accept = req_valid && !busy;

  xms_stretch_reg #(.SW(SW), .RESET_VAL(RESET_STR)) i_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .value(cfg_stretch)
  );

  xms_phase_ctr #(.CW(CW)) i_ctr (
    .clk(clk), .rst_n(rst_n), .start(accept), .len(len),
    .active(busy), .idx(idx), .last(last)
  );

  xms_strobe_gen #(.SW(SW), .CW(CW)) i_stb (
    .active(busy), .is_write(cur_write), .stretch(cur_stretch), .idx(idx),
    .len(len), .rd(rd_s), .wr(wr_s)
  );

  // request snapshot; short form clears the upper address bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_write   <= 1'b0;
      cur_short   <= 1'b0;
      cur_stretch <= '0;
      cur_addr    <= '0;
      cur_wdata   <= '0;
    end else if (accept) begin
      cur_write   <= req_write;
      cur_short   <= req_short;
      cur_stretch <= cfg_stretch;
      cur_wdata   <= req_wdata;
      cur_addr    <= req_short ? {{(ADDR_W-SHORT_W){1'b0}}, req_addr[SHORT_W-1:0]}
                               : req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= last;
      if (last && !cur_write) rdata <= bus_din;
    end
  end

  assign bus_addr = busy ? cur_addr : '0;
  assign bus_rd   = rd_s;
  assign bus_wr   = wr_s;
  assign bus_dout = wr_s ? cur_wdata : '0;
endmodule

// File: rtl/xms_checker.sv
module xms_checker #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              cur_short,
  input logic              cur_write
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!bus_rd && !bus_wr)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(bus_addr)); // R7
  AST_SHORT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (busy && cur_short) |-> (bus_addr[ADDR_W-1:8] == '0)); // R7
  AST_WR_LEAD: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_wr) |-> $past(busy)); // R6
  AST_RD_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) ($rose(busy) && !cur_write) |-> bus_rd); // R3
endmodule

bind xmem_stretch_ctrl xms_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .cur_short(cur_short), .cur_write(cur_write)
);

// File: tb/test_xmem_stretch_ctrl.sv
module test_xmem_stretch_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_wdata = '0;
  logic [2:0]  cfg_stretch;
  logic        req_valid = 1'b0, req_write = 1'b0, req_short = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, done, bus_rd, bus_wr;
  logic [7:0]  rdata, bus_dout;
  logic [15:0] bus_addr;
  logic [7:0]  bus_din = '0;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  xmem_stretch_ctrl i_xmem_stretch_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_stretch(cfg_stretch), .req_valid(req_valid), .req_write(req_write),
    .req_short(req_short), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_dout(bus_dout), .bus_din(bus_din)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 3'(s);
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_stretch == 3'(s), "R2 readback", int'(cfg_stretch), s);
  endtask

  // one access; s is the stretch value the access must use
  task automatic access(input bit wr, input bit sh, input logic [15:0] a,
                        input logic [7:0] d, input int s,
                        input bit poke, input bit mid_cfg, input int newcfg);
    int exp_len = wr ? s + 2 : s + 1;
    int exp_w   = (s < 2) ? 1 : s;
    logic [15:0] exp_a = sh ? {8'h00, a[7:0]} : a;
    int nb = 0, nrd = 0, nwr = 0, first = -1, lastw = -1;
    int addr_bad = 0, dout_bad = 0, idle_bad = 0, ndone = 0, done_at = -1;
    logic [7:0] got_rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_short = sh; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = poke; req_addr = ~a; req_write = ~wr;
    for (int i = 0; i < 13; i++) begin
      if (i == 0 && mid_cfg) begin cfg_we = 1'b1; cfg_wdata = 3'(newcfg); end
      if (i == 1) begin cfg_we = 1'b0; req_valid = 1'b0; end
      if (busy) begin
        if (bus_addr != exp_a) addr_bad++;
        if (bus_rd) nrd++;
        if (bus_wr) begin
          if (first < 0) first = nb;
          lastw = nb;
          nwr++;
          if (bus_dout != d) dout_bad++;
        end
        bus_din = 8'h40 + 8'(nb);
        nb++;
      end else begin
        if (bus_rd || bus_wr) idle_bad++;
        bus_din = 8'hEE;
      end
      if (done) begin ndone++; done_at = i; got_rd = rdata; end
      @(negedge clk);
    end
    chk(nb == exp_len, wr ? "R4 address phase" : "R3 address phase", nb, exp_len);
    chk(nrd == (wr ? 0 : exp_len), "R3 read strobe width", nrd, wr ? 0 : exp_len);
    chk(nwr == (wr ? exp_w : 0), "R5 write strobe width", nwr, wr ? exp_w : 0);
    if (wr) begin
      chk(first == 1, "R6 strobe start", first, 1);
      if (s >= 1) chk(lastw == exp_len - 2, "R6 trailing hold", lastw, exp_len - 2);
      chk(dout_bad == 0, "R10 write data", dout_bad, 0);
    end
    chk(addr_bad == 0, "R7 address value", addr_bad, 0);
    chk(idle_bad == 0, "R10 idle strobes", idle_bad, 0);
    chk(ndone == 1 && done_at == exp_len, "R8 done timing", done_at, exp_len);
    if (!wr) chk(got_rd == 8'h40 + 8'(s), "R8 read capture", int'(got_rd), 8'h40 + s);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20;
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_stretch == 3'd1, "R1 reset stretch", int'(cfg_stretch), 1);
    chk(!busy && !done && !bus_rd && !bus_wr, "R1 idle outputs", int'({busy, done, bus_rd, bus_wr}), 0);
    // default stretch of 1 used without any configuration write
    access(1'b0, 1'b0, 16'h1234, 8'h00, 1, 1'b0, 1'b0, 0);
    access(1'b1, 1'b0, 16'hFFFF, 8'h5A, 1, 1'b0, 1'b0, 0);
    // sweep of every stretch value, direction and address form
    for (int s = 0; s < 8; s++) begin
      set_cfg(s);
      for (int w = 0; w < 2; w++)
        for (int sh = 0; sh < 2; sh++)
          access(w[0], sh[0], 16'hA5C3 ^ 16'(s * 4369 + w * 257 + sh * 16),
                 8'(8'h3C + s * 7 + w), s, 1'b0, 1'b0, 0);
    end
    // R2: change stretch during an access, then check the next access
    set_cfg(2);
    access(1'b1, 1'b0, 16'h0F0F, 8'h81, 2, 1'b0, 1'b1, 6);
    chk(cfg_stretch == 3'd6, "R2 mid-access write visible", int'(cfg_stretch), 6);
    access(1'b0, 1'b0, 16'hF0F0, 8'h00, 6, 1'b0, 1'b0, 0);
    // R9: request held while busy is ignored
    access(1'b0, 1'b1, 16'hBEEF, 8'h00, 6, 1'b1, 1'b0, 0);
    set_cfg(0);
    access(1'b0, 1'b0, 16'h0001, 8'h00, 0, 1'b1, 1'b0, 0);
    access(1'b1, 1'b0, 16'h8000, 8'h77, 0, 1'b1, 1'b0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule